// File: doc/BRIEF.md
# Pattern-Memory Bank and Mirroring Decoder

This block turns a cartridge controller's configuration into the page layout of the 8 KB pattern window in the video address space. It takes a layout select bit, a two-bit nametable arrangement code and two five-bit bank registers. From these it works out which two 4 KB banks of pattern memory are visible. Each bank is split into four 1 KB pages, which gives the eight page numbers the window shows.

The configuration is captured into registers on a clock-enabled load pulse. The page table and the arrangement code then stay fixed until the next load. A video-side address is translated to a physical pattern-memory address without a clock delay. Address bit 12 picks the bank, address bits [11:10] pick the page inside that bank, and the low ten bits pass through unchanged. The number of 4 KB banks fitted is a power-of-two parameter, so bank numbers are reduced by masking.

Top module: `chr_mirror_map`

## Requirements
- R1: After reset, page slots 0..7 hold page numbers 0..7, which is lower bank 0 and upper bank 1. The arrangement output is 0.
- R2: The arrangement output takes the value of mirror_i from the load. The codes are 0 for single-screen lower, 1 for single-screen upper, 2 for vertical and 3 for horizontal.
- R3: With chr_4k_i = 0 at load (paired 8 KB layout), the lower bank is chr_lo_i reduced modulo the bank count with its bit 0 cleared. The upper bank is the lower bank plus 1. chr_hi_i has no effect.
- R4: With chr_4k_i = 1 at load (independent layout), the lower bank is chr_lo_i and the upper bank is chr_hi_i, each reduced modulo the bank count.
- R5: Bank register bits at or above log2(CHR_BANKS) are discarded. This includes bit 4.
- R6: Slot k (0..3) holds lower_bank*4+k and slot 4+k holds upper_bank*4+k. Slot k occupies page_o bits [k*PAGE_W +: PAGE_W].
- R7: chr_addr_o = page(slot ppu_addr_i[12:10])*1024 + ppu_addr_i[9:0]. It follows ppu_addr_i in the same cycle.
- R8: While load_i is low, page_o and mirror_o keep their values whatever the configuration inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Clock enable that captures the configuration |
| chr_4k_i | input | 1 | Layout select: 0 for the paired 8 KB layout, 1 for independent 4 KB halves |
| mirror_i | input | 2 | Nametable arrangement code |
| chr_lo_i | input | 5 | Bank register for the lower half |
| chr_hi_i | input | 5 | Bank register for the upper half |
| ppu_addr_i | input | 13 | Video-side pattern address |
| page_o | output | 8*PAGE_W | Page number of each 1 KB slot, packed |
| mirror_o | output | 2 | Registered arrangement code |
| chr_addr_o | output | PAGE_W+10 | Physical pattern-memory address |

## Verification
A wrong bank register shows on page_o in the cycle right after the load that wrote it. The same error shows on chr_addr_o as soon as an address falls in the affected half, with no added latency. Because of this, every load is followed by a check of all eight slots and the arrangement code one cycle later, and a sweep of all eight address slots catches a page selected from the wrong slot. A bank number that was reduced incorrectly or left with bit 0 set shows up as a page number out of range or off by four.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int REG_W      = 5;
  localparam int NUM_SLOTS  = 8;
  localparam int SLOT_SEL_W = 3;
  localparam int PAGE_OFS_W = 10;
  localparam int VADDR_W    = SLOT_SEL_W + PAGE_OFS_W;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;
endpackage

// File: rtl/chr_bank_sel.sv
module chr_bank_sel
  import chr_map_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              chr_4k_i,
  input  logic [REG_W-1:0]  chr_lo_i,
  input  logic [REG_W-1:0]  chr_hi_i,
  output logic [BANK_W-1:0] bank_lo_o,
  output logic [BANK_W-1:0] bank_hi_o
);
  logic [BANK_W-1:0] lo_mod;
  logic [BANK_W-1:0] hi_mod;

  // power-of-two bank count: modulo is a truncation
  assign lo_mod = chr_lo_i[BANK_W-1:0];
  assign hi_mod = chr_hi_i[BANK_W-1:0];

  always_comb begin
    if (chr_4k_i) begin
      bank_lo_o = lo_mod;
      bank_hi_o = hi_mod;
    end else begin
      bank_lo_o = {lo_mod[BANK_W-1:1], 1'b0};
      bank_hi_o = {lo_mod[BANK_W-1:1], 1'b1};
    end
  end
endmodule

// File: rtl/chr_page_expand.sv
module chr_page_expand
  import chr_map_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int PAGE_W = BANK_W + 2
) (
  input  logic [BANK_W-1:0]           bank_lo_i,
  input  logic [BANK_W-1:0]           bank_hi_i,
  output logic [NUM_SLOTS*PAGE_W-1:0] pages_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [1:0] SUB = 2'(k % 4);
    if (k < 4) begin : g_lo
      assign pages_o[k*PAGE_W +: PAGE_W] = {bank_lo_i, SUB};
    end else begin : g_hi
      assign pages_o[k*PAGE_W +: PAGE_W] = {bank_hi_i, SUB};
    end
  end
endmodule

// File: rtl/chr_addr_map.sv
module chr_addr_map
  import chr_map_pkg::*;
#(
  parameter int PAGE_W = 6,
  localparam int PHYS_W = PAGE_W + PAGE_OFS_W
) (
  input  logic [NUM_SLOTS*PAGE_W-1:0] pages_i,
  input  logic [VADDR_W-1:0]          vaddr_i,
  output logic [PHYS_W-1:0]           paddr_o
);
  logic [SLOT_SEL_W-1:0] slot;
  logic [PAGE_W-1:0]     page;

  assign slot    = vaddr_i[VADDR_W-1:PAGE_OFS_W];
  assign page    = pages_i[slot*PAGE_W +: PAGE_W];
  assign paddr_o = {page, vaddr_i[PAGE_OFS_W-1:0]};
endmodule

// File: rtl/chr_mirror_map.sv
module chr_mirror_map
  import chr_map_pkg::*;
#(
  parameter int CHR_BANKS = 16,
  localparam int BANK_W = $clog2(CHR_BANKS),
  localparam int PAGE_W = BANK_W + 2,
  localparam int PHYS_W = PAGE_W + PAGE_OFS_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        chr_4k_i,
  input  logic [1:0]                  mirror_i,
  input  logic [REG_W-1:0]            chr_lo_i,
  input  logic [REG_W-1:0]            chr_hi_i,
  input  logic [VADDR_W-1:0]          ppu_addr_i,
  output logic [NUM_SLOTS*PAGE_W-1:0] page_o,
  output logic [1:0]                  mirror_o,
  output logic [PHYS_W-1:0]           chr_addr_o
);
  logic [BANK_W-1:0] sel_lo, sel_hi;
  logic [BANK_W-1:0] bank_lo_d, bank_hi_d, bank_lo_q, bank_hi_q;
  mirror_e           mirror_d, mirror_q;

  chr_bank_sel #(.BANK_W(BANK_W)) u_sel (
    .chr_4k_i (chr_4k_i),
    .chr_lo_i (chr_lo_i),
    .chr_hi_i (chr_hi_i),
    .bank_lo_o(sel_lo),
    .bank_hi_o(sel_hi)
  );

  always_comb begin
    bank_lo_d = bank_lo_q;
    bank_hi_d = bank_hi_q;
    mirror_d  = mirror_q;
    if (load_i) begin
      bank_lo_d = sel_lo;
      bank_hi_d = sel_hi;
      mirror_d  = mirror_e'(mirror_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_lo_q <= '0;
      bank_hi_q <= BANK_W'(1);
      mirror_q  <= MIR_ONE_LO;
    end else begin
      bank_lo_q <= bank_lo_d;
      bank_hi_q <= bank_hi_d;
      mirror_q  <= mirror_d;
    end
  end

  chr_page_expand #(.BANK_W(BANK_W)) u_exp (
    .bank_lo_i(bank_lo_q),
    .bank_hi_i(bank_hi_q),
    .pages_o  (page_o)
  );

  chr_addr_map #(.PAGE_W(PAGE_W)) u_amap (
    .pages_i(page_o),
    .vaddr_i(ppu_addr_i),
    .paddr_o(chr_addr_o)
  );

  assign mirror_o = mirror_q;
endmodule

// File: rtl/chr_mirror_map_chk.sv
module chr_mirror_map_chk
  import chr_map_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        load_i,
  input logic                        chr_4k_i,
  input logic [1:0]                  mirror_i,
  input logic [VADDR_W-1:0]          ppu_addr_i,
  input logic [NUM_SLOTS*PAGE_W-1:0] page_o,
  input logic [1:0]                  mirror_o,
  input logic [PAGE_W+PAGE_OFS_W-1:0] chr_addr_o
);
  // R2
  mirror_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> mirror_o == $past(mirror_i));

  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(page_o) && $stable(mirror_o)));

  // R3
  paired_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !chr_4k_i) |=> (page_o[2] == 1'b0 && page_o[4*PAGE_W+2] == 1'b1
      && page_o[4*PAGE_W +: PAGE_W] == page_o[0 +: PAGE_W] + PAGE_W'(4)));

  // R6
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_o[0 +: 2] == 2'd0 && page_o[3*PAGE_W +: PAGE_W] == page_o[0 +: PAGE_W] + PAGE_W'(3)
      && page_o[7*PAGE_W +: PAGE_W] == page_o[4*PAGE_W +: PAGE_W] + PAGE_W'(3)));

  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr_o[PAGE_OFS_W-1:0] == ppu_addr_i[PAGE_OFS_W-1:0]);
endmodule

bind chr_mirror_map chr_mirror_map_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .chr_4k_i  (chr_4k_i),
  .mirror_i  (mirror_i),
  .ppu_addr_i(ppu_addr_i),
  .page_o    (page_o),
  .mirror_o  (mirror_o),
  .chr_addr_o(chr_addr_o)
);

// File: tb/chr_mirror_map_test.sv
module chr_mirror_map_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 6;
  localparam int PHYS_W = PAGE_W + 10;
  localparam int NVEC = 6;
  // {chr_4k, mirror[1:0], lo[4:0], hi[4:0], exp_lo[3:0], exp_hi[3:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 5'd5,  5'd9,  4'd4,  4'd5},   // R3
    {1'b0, 2'd1, 5'd31, 5'd0,  4'd14, 4'd15},  // R3 R5
    {1'b1, 2'd2, 5'd3,  5'd12, 4'd3,  4'd12},  // R4
    {1'b1, 2'd3, 5'd23, 5'd26, 4'd7,  4'd10},  // R4 R5
    {1'b1, 2'd0, 5'd16, 5'd31, 4'd0,  4'd15},  // R5
    {1'b0, 2'd3, 5'd18, 5'd7,  4'd2,  4'd3}    // R3 R5
  };

  logic clk = 1'b0, rst_n = 1'b0, load_i = 1'b0, chr_4k_i = 1'b0;
  logic [1:0] mirror_i = '0;
  logic [4:0] chr_lo_i = '0, chr_hi_i = '0;
  logic [12:0] ppu_addr_i = '0;
  logic [8*PAGE_W-1:0] page_o;
  logic [1:0] mirror_o;
  logic [PHYS_W-1:0] chr_addr_o;
  int n_chk = 0, n_bad = 0;
  logic [8*PAGE_W-1:0] exp_pages;
  logic [8*PAGE_W-1:0] snap;

  chr_mirror_map #(.CHR_BANKS(16)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8*PAGE_W-1:0] build(input int lo, input int hi);
    logic [8*PAGE_W-1:0] p;
    for (int k = 0; k < 8; k++)
      p[k*PAGE_W +: PAGE_W] = PAGE_W'(((k < 4) ? lo : hi) * 4 + (k % 4));
    return p;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic m4k, input logic [1:0] mir, input logic [4:0] lo, input logic [4:0] hi);
    @(negedge clk);
    chr_4k_i = m4k; mirror_i = mir; chr_lo_i = lo; chr_hi_i = hi; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pages", page_o, build(0, 1));
    check("R1 mirror", mirror_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ppu_addr_i = 13'h1FFF;
    #1 check("R1 R7 addr", chr_addr_o, 16'h1FFF);

    for (int v = 0; v < NVEC; v++) begin
      load_cfg(VEC[v][20], VEC[v][19:18], VEC[v][17:13], VEC[v][12:8]);
      exp_pages = build(int'(VEC[v][7:4]), int'(VEC[v][3:0]));
      check("R3 R4 R5 R6 pages", page_o, exp_pages);
      check("R2 mirror", mirror_o, VEC[v][19:18]);
      ppu_addr_i = 13'h1000 | 13'(v * 37);
      #1 check("R7 addr", chr_addr_o, longint'(VEC[v][3:0]) * 4096 + v * 37);
    end

    // R3: upper register must not matter in the paired layout
    load_cfg(1'b0, 2'd2, 5'd9, 5'd0);
    snap = page_o;
    load_cfg(1'b0, 2'd2, 5'd9, 5'd31);
    check("R3 hi ignored", page_o, snap);
    check("R3 value", page_o, build(8, 9));

    // R8: inputs change without load
    @(negedge clk);
    chr_4k_i = 1'b1; mirror_i = 2'd1; chr_lo_i = 5'd1; chr_hi_i = 5'd2;
    repeat (3) @(negedge clk);
    check("R8 pages held", page_o, build(8, 9));
    check("R8 mirror held", mirror_o, 2);

    // R7 sweep of all slots, independent layout
    load_cfg(1'b1, 2'd3, 5'd6, 5'd13);
    for (int s = 0; s < 8; s++) begin
      ppu_addr_i = 13'(s * 1024 + 5 + s);
      #1 check("R7 slot", chr_addr_o, ((s < 4 ? 6 : 13) * 4 + (s % 4)) * 1024 + 5 + s);
    end

    // R1 again: asynchronous reset restores defaults
    #2 rst_n = 1'b0;
    #1 check("R1 reset pages", page_o, build(0, 1));
    check("R1 reset mirror", mirror_o, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule